// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block sends asynchronous serial characters on a single output line. A character is written into a one-entry holding buffer; at the next bit tick after the line goes idle, or exactly at the end of the frame in flight, the buffer contents move into a shift register. The buffer is then free for the next character, so a steady writer gets frames with no idle time between them. Bit timing comes from an external baud generator. That generator supplies a one-cycle `bit_tick` pulse per bit period, and every state change of the shifter happens on such a pulse.

Each frame has a low start bit, then 5 to 9 data bits sent least significant first, then an optional parity bit, then one or two high stop bits. The ninth data bit is presented on its own input and is captured in the same cycle as the low data bits.

Two status flags report progress:
- `buf_empty` shows that the buffer can take a character.
- `tx_done` shows that a whole frame has left and nothing is waiting. Software clears it by writing one, or by acknowledging its interrupt.

Each flag has an interrupt request, gated by its own enable and by a global enable.

The shifter is a state machine with the states IDLE, START, DATA, PARITY, STOP1 and STOP2, and these transitions, each taken only on a bit tick while enabled:
- IDLE to START when the buffer is full (load).
- START to DATA.
- DATA to DATA while data bits remain (shift).
- DATA to PARITY or STOP1 after the last data bit.
- PARITY to STOP1.
- STOP1 to STOP2 when two stop bits are configured.
- STOP1 or STOP2 to START when the buffer is full (back-to-back load).
- STOP1 or STOP2 to IDLE otherwise (frame complete).

Whenever `tx_en` is low, the machine returns to IDLE.

Top module: `ftx_top`

## Requirements
- R1: After reset `buf_empty` is 1 and `tx_done` is 0, `tx_o` is 1, and both interrupt requests are 0.
- R2: The line is 1 while idle. A frame starts with one 0 bit and sends data bits least significant first. Each serial bit lasts from one `bit_tick` to the next.
- R3: `cfg_dbits` selects 5, 6, 7, 8 or 9 data bits. Bits of the written character above that length do not reach the line.
- R4: `cfg_parity` selects the parity bit. Codes 00 and 01 send no parity bit. Code 10 sends even parity, so the data bits plus the parity bit hold an even number of ones. Code 11 sends odd parity. The parity bit follows the last data bit.
- R5: `cfg_stop2` = 0 sends one stop bit of 1, and `cfg_stop2` = 1 sends two.
- R6: Data bit 8 (the ninth) is the value of `bit8_in` in the cycle of the accepted write. Later changes of `bit8_in` do not affect that character.
- R7: `buf_empty` is 1 exactly when the buffer can accept a character. A write while it is 0 is ignored and produces no frame.
- R8: `tx_done` is set when a frame's last stop bit ends and no character is waiting. It stays 0 while a waiting character follows on directly.
- R9: A one-cycle pulse on `done_clr` or on `done_ack` clears `tx_done`.
- R10: `irq_empty` is `ie_empty & gie & buf_empty`, and `irq_done` is `ie_done & gie & tx_done`.
- R11: A character waiting at the end of a frame starts at the very next bit tick, with no idle bit between the frames.
- R12: While `tx_en` is 0, `tx_drive` is 0 and `tx_o` is 1. A character written meanwhile is held, and it is sent once `tx_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit period from the baud generator |
| tx_en | input | 1 | Transmitter enable; when 1 the block owns the line |
| wr_stb | input | 1 | Write strobe for the holding buffer |
| wr_data | input | DATA_W-1 (8) | Low data bits of the character |
| bit8_in | input | 1 | Ninth data bit, captured with `wr_stb` |
| cfg_dbits | input | CW (4) | Data bit count 5..9; smaller values act as 5, larger as 9 |
| cfg_parity | input | 2 | 0x: none, 10: even, 11: odd |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| gie | input | 1 | Global interrupt enable |
| ie_empty | input | 1 | Enable for the buffer-empty interrupt |
| ie_done | input | 1 | Enable for the transmit-complete interrupt |
| done_clr | input | 1 | Write-one-to-clear pulse for `tx_done` |
| done_ack | input | 1 | Interrupt acknowledge pulse for `tx_done` |
| tx_o | output | 1 | Serial output line |
| tx_drive | output | 1 | High when the transmitter owns the line |
| buf_empty | output | 1 | Holding buffer can accept a character |
| tx_done | output | 1 | Transmit-complete flag |
| irq_empty | output | 1 | Buffer-empty interrupt request |
| irq_done | output | 1 | Transmit-complete interrupt request |

## Verification
The bench builds the block with its defaults, DATA_W = 9 and MIN_BITS = 5. With these values the full range from 5 to 9 data bits is reachable, and so is the separate ninth-bit path. Bit ticks arrive every fourth clock, which keeps a longest frame of 13 bits short. That in turn allows many random bursts, each with a random length, parity mode and stop count. Directed sequences reach three further cases: a write into a full buffer, a frame handed over back to back, and a character held while the line is released.

// File: rtl/ftx_pkg.sv
package ftx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2
    } ftx_state_e;

endpackage

// File: rtl/ftx_holding.sv
module ftx_holding #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-2:0] wr_data,
    input  logic              bit8_in,
    input  logic              take,
    output logic [DATA_W-1:0] hold_q,
    output logic              hold_full
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q    <= '0;
            hold_full <= 1'b0;
        end else if (take) begin
            hold_full <= 1'b0;
        end else if (wr_stb && !hold_full) begin
            hold_q    <= {bit8_in, wr_data};
            hold_full <= 1'b1;
        end
    end

endmodule

// File: rtl/ftx_shifter.sv
module ftx_shifter
    import ftx_pkg::*;
#(
    parameter int DATA_W   = 9,
    parameter int MIN_BITS = 5,
    localparam int CW      = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              bit_tick,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_q,
    input  logic [CW-1:0]     cfg_dbits,
    input  logic [1:0]        cfg_parity,
    input  logic              cfg_stop2,
    output logic              take,
    output logic              frame_done,
    output logic              line
);

    ftx_state_e        state, nxt;
    logic [DATA_W-1:0] shreg, masked;
    logic [CW-1:0]     cnt, n_q, n_eff;
    logic              par_en_q, stop2_q, par_bit;
    logic              shift, frame_end;

    // Effective length, clamped into the legal range.
    always_comb begin
        if (cfg_dbits < CW'(MIN_BITS))     n_eff = CW'(MIN_BITS);
        else if (cfg_dbits > CW'(DATA_W))  n_eff = CW'(DATA_W);
        else                               n_eff = cfg_dbits;
    end

    // Bits above the configured length are dropped.
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign masked[i] = hold_q[i] & (CW'(i) < n_eff);
    end

    // Next state.
    always_comb begin
        nxt       = state;
        take      = 1'b0;
        frame_done = 1'b0;
        shift     = 1'b0;
        frame_end = 1'b0;
        if (!tx_en) begin
            nxt = ST_IDLE;
        end else if (bit_tick) begin
            unique case (state)
                ST_IDLE:   if (hold_full) begin
                               nxt  = ST_START;
                               take = 1'b1;
                           end
                ST_START:  nxt = ST_DATA;
                ST_DATA:   if (cnt == n_q - CW'(1))
                               nxt = par_en_q ? ST_PARITY : ST_STOP1;
                           else
                               shift = 1'b1;
                ST_PARITY: nxt = ST_STOP1;
                ST_STOP1:  if (stop2_q) nxt = ST_STOP2;
                           else         frame_end = 1'b1;
                ST_STOP2:  frame_end = 1'b1;
                default:   nxt = ST_IDLE;
            endcase
            if (frame_end) begin
                if (hold_full) begin
                    nxt  = ST_START;
                    take = 1'b1;
                end else begin
                    nxt        = ST_IDLE;
                    frame_done = 1'b1;
                end
            end
        end
    end

    // State register and datapath.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            cnt      <= '0;
            n_q      <= CW'(MIN_BITS);
            par_en_q <= 1'b0;
            stop2_q  <= 1'b0;
            par_bit  <= 1'b0;
        end else begin
            state <= nxt;
            if (take) begin
                shreg    <= masked;
                cnt      <= '0;
                n_q      <= n_eff;
                par_en_q <= cfg_parity[1];
                stop2_q  <= cfg_stop2;
                par_bit  <= (^masked) ^ cfg_parity[0];
            end else if (shift) begin
                shreg <= shreg >> 1;
                cnt   <= cnt + CW'(1);
            end
        end
    end

    // Line output.
    always_comb begin
        unique case (state)
            ST_IDLE:   line = 1'b1;
            ST_START:  line = 1'b0;
            ST_DATA:   line = shreg[0];
            ST_PARITY: line = par_bit;
            ST_STOP1,
            ST_STOP2:  line = 1'b1;
            default:   line = 1'b1;
        endcase
    end

endmodule

// File: rtl/ftx_status.sv
module ftx_status (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_done,
    input  logic done_clr,
    input  logic done_ack,
    input  logic buf_empty,
    input  logic gie,
    input  logic ie_empty,
    input  logic ie_done,
    output logic tx_done,
    output logic irq_empty,
    output logic irq_done
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    tx_done <= 1'b0;
        else if (frame_done)           tx_done <= 1'b1;
        else if (done_clr || done_ack) tx_done <= 1'b0;
    end

    assign irq_empty = ie_empty & gie & buf_empty;
    assign irq_done  = ie_done & gie & tx_done;

endmodule

// File: rtl/ftx_top.sv
module ftx_top #(
    parameter int DATA_W   = 9,
    parameter int MIN_BITS = 5,
    localparam int CW      = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              tx_en,
    input  logic              wr_stb,
    input  logic [DATA_W-2:0] wr_data,
    input  logic              bit8_in,
    input  logic [CW-1:0]     cfg_dbits,
    input  logic [1:0]        cfg_parity,
    input  logic              cfg_stop2,
    input  logic              gie,
    input  logic              ie_empty,
    input  logic              ie_done,
    input  logic              done_clr,
    input  logic              done_ack,
    output logic              tx_o,
    output logic              tx_drive,
    output logic              buf_empty,
    output logic              tx_done,
    output logic              irq_empty,
    output logic              irq_done
);

    logic [DATA_W-1:0] hold_q;
    logic              hold_full, take, frame_done, line;

    ftx_holding #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .bit8_in   (bit8_in),
        .take      (take),
        .hold_q    (hold_q),
        .hold_full (hold_full)
    );

    ftx_shifter #(.DATA_W(DATA_W), .MIN_BITS(MIN_BITS)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .bit_tick   (bit_tick),
        .hold_full  (hold_full),
        .hold_q     (hold_q),
        .cfg_dbits  (cfg_dbits),
        .cfg_parity (cfg_parity),
        .cfg_stop2  (cfg_stop2),
        .take       (take),
        .frame_done (frame_done),
        .line       (line)
    );

    assign buf_empty = ~hold_full;

    ftx_status u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .done_clr   (done_clr),
        .done_ack   (done_ack),
        .buf_empty  (buf_empty),
        .gie        (gie),
        .ie_empty   (ie_empty),
        .ie_done    (ie_done),
        .tx_done    (tx_done),
        .irq_empty  (irq_empty),
        .irq_done   (irq_done)
    );

    assign tx_o     = tx_en ? line : 1'b1;
    assign tx_drive = tx_en;

endmodule

// File: rtl/ftx_checker.sv
module ftx_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic wr_stb,
    input logic buf_empty,
    input logic tx_done,
    input logic done_clr,
    input logic done_ack,
    input logic gie,
    input logic irq_empty,
    input logic irq_done,
    input logic tx_o,
    input logic tx_drive
);

    a_r1_reset_flags: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (buf_empty && !tx_done));

    a_r7_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && buf_empty) |=> !buf_empty);

    a_r8_done_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> $past(buf_empty));

    a_r9_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_done) |-> $past(done_clr || done_ack));

    a_r10_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> (!irq_empty && !irq_done));

    a_r12_released: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> (tx_o && !tx_drive));

endmodule

bind ftx_top ftx_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .wr_stb    (wr_stb),
    .buf_empty (buf_empty),
    .tx_done   (tx_done),
    .done_clr  (done_clr),
    .done_ack  (done_ack),
    .gie       (gie),
    .irq_empty (irq_empty),
    .irq_done  (irq_done),
    .tx_o      (tx_o),
    .tx_drive  (tx_drive)
);

// File: tb/ftx_top_bench.sv
module ftx_top_bench;

    localparam int DATA_W = 9;
    localparam int CW     = $clog2(DATA_W + 1);
    localparam int DIV    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b0, tx_en = 1'b1, wr_stb = 1'b0, bit8_in = 1'b0;
    logic [DATA_W-2:0] wr_data = '0;
    logic [CW-1:0] cfg_dbits = CW'(8);
    logic [1:0] cfg_parity = 2'b00;
    logic cfg_stop2 = 1'b0;
    logic gie = 1'b0, ie_empty = 1'b0, ie_done = 1'b0, done_clr = 1'b0, done_ack = 1'b0;
    logic tx_o, tx_drive, buf_empty, tx_done, irq_empty, irq_done;

    ftx_top u_ftx_top (.*);

    always #4 clk = ~clk;

    int checks = 0, fails = 0;
    logic [DATA_W-1:0] expq[$];
    bit   in_frame = 0;
    int   got = 0, idle_cnt = 0, last_gap = -1, frames_seen = 0, div_cnt = 0;
    logic [15:0] rx_vec;
    bit   prev_done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int frame_len(input int n, input logic [1:0] pm, input logic s2);
        return 2 + n + int'(pm[1]) + int'(s2);
    endfunction

    function automatic logic [15:0] frame_vec(input logic [DATA_W-1:0] d, input int n,
                                              input logic [1:0] pm, input logic s2);
        logic [15:0] v = '1;
        logic p = 1'b0;
        int k;
        v[0] = 1'b0;
        for (int i = 0; i < n; i++) begin
            v[1+i] = d[i];
            p ^= d[i];
        end
        k = 1 + n;
        if (pm[1]) begin
            v[k] = p ^ pm[0];
            k++;
        end
        v[k] = 1'b1;
        if (s2) v[k+1] = 1'b1;
        return v;
    endfunction

    function automatic string tag_of(input int n, input logic [1:0] pm, input logic s2);
        return $sformatf("R2/R3%s%s%s", pm[1] ? "/R4" : "", s2 ? "/R5" : "",
                         (n == 9) ? "/R6" : "");
    endfunction

    // Line decoder and tick generator, all at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (bit_tick) begin
                if (!in_frame) begin
                    if (tx_o == 1'b0) begin
                        in_frame = 1;
                        got = 1;
                        rx_vec = '1;
                        rx_vec[0] = 1'b0;
                        last_gap = idle_cnt;
                        idle_cnt = 0;
                    end else begin
                        idle_cnt++;
                    end
                end else begin
                    int len;
                    len = frame_len(int'(cfg_dbits), cfg_parity, cfg_stop2);
                    rx_vec[got] = tx_o;
                    got++;
                    if (got == len) begin
                        logic [15:0] ev;
                        logic [15:0] mk;
                        in_frame = 0;
                        frames_seen++;
                        mk = 16'((32'd1 << len) - 1);
                        if (expq.size() == 0) begin
                            chk(0, "R7 unexpected frame", int'(rx_vec & mk), 0);
                        end else begin
                            ev = frame_vec(expq.pop_front(), int'(cfg_dbits), cfg_parity, cfg_stop2);
                            chk((rx_vec & mk) == (ev & mk),
                                tag_of(int'(cfg_dbits), cfg_parity, cfg_stop2),
                                int'(rx_vec & mk), int'(ev & mk));
                        end
                    end
                end
            end
            if (tx_done && !prev_done)
                chk(expq.size() == 0 && !in_frame, "R8 done raised with work pending",
                    expq.size(), 0);
            prev_done = tx_done;
            div_cnt = (div_cnt == DIV - 1) ? 0 : div_cnt + 1;
            bit_tick = (div_cnt == 0);
        end
    end

    task automatic wr(input logic [DATA_W-2:0] d, input logic b8);
        bit8_in = b8;
        @(negedge clk);
        wr_data = d;
        wr_stb = 1'b1;
        if (buf_empty) expq.push_back({b8, d});
        @(negedge clk);
        wr_stb = 1'b0;
        bit8_in = ~b8;
        wr_data = DATA_W'($urandom);
    endtask

    task automatic wait_empty();
        while (!buf_empty) @(negedge clk);
    endtask

    task automatic wait_done();
        while (!tx_done) @(negedge clk);
        chk(expq.size() == 0, "R8 queue drained at done", expq.size(), 0);
    endtask

    task automatic clear_done(input bit use_ack);
        if (use_ack) done_ack = 1'b1; else done_clr = 1'b1;
        @(negedge clk);
        done_ack = 1'b0;
        done_clr = 1'b0;
        chk(tx_done == 1'b0, use_ack ? "R9 ack clears" : "R9 clr clears", tx_done, 0);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int seen0;
        void'($urandom(32'd1234));
        @(negedge clk);
        chk(buf_empty && !tx_done && tx_o && !irq_empty && !irq_done, "R1 in reset",
            {buf_empty, tx_done, tx_o, irq_empty, irq_done}, 5'b10100);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(buf_empty && !tx_done && tx_o, "R1 after reset",
            {buf_empty, tx_done, tx_o}, 3'b101);

        // Back-to-back pair, then a write into a full buffer.
        seen0 = frames_seen;
        wr(8'hA5, 1'b0);
        wait_empty();
        wr(8'h3C, 1'b0);
        chk(buf_empty == 1'b0, "R7 buffer full while waiting", buf_empty, 0);
        wr(8'hFF, 1'b1);
        chk(buf_empty == 1'b0, "R7 write while full ignored", buf_empty, 0);
        wait_done();
        chk(last_gap == 0, "R11 no idle between frames", last_gap, 0);
        chk(frames_seen - seen0 == 2, "R7 only accepted frames sent", frames_seen - seen0, 2);

        // Interrupt gating with both flags set.
        for (int c = 0; c < 8; c++) begin
            gie = c[0]; ie_empty = c[1]; ie_done = c[2];
            @(negedge clk);
            chk(irq_empty == (c[0] & c[1]), "R10 irq_empty", irq_empty, c[0] & c[1]);
            chk(irq_done == (c[0] & c[2]), "R10 irq_done", irq_done, c[0] & c[2]);
        end
        clear_done(1'b1);
        gie = 1'b1; ie_done = 1'b1;
        @(negedge clk);
        chk(irq_done == 1'b0, "R10 irq_done drops with flag", irq_done, 0);
        gie = 1'b0; ie_empty = 1'b0; ie_done = 1'b0;

        // Line released while a character waits.
        tx_en = 1'b0;
        seen0 = frames_seen;
        wr(8'h81, 1'b0);
        repeat (20 * DIV) @(negedge clk);
        chk(tx_o && !tx_drive, "R12 line released", {tx_o, tx_drive}, 2'b10);
        chk(buf_empty == 1'b0, "R12 character held", buf_empty, 0);
        chk(frames_seen == seen0, "R12 nothing sent", frames_seen - seen0, 0);
        tx_en = 1'b1;
        @(negedge clk);
        chk(tx_drive == 1'b1, "R12 line driven again", tx_drive, 1);
        wait_done();
        clear_done(1'b0);

        // Random bursts over all lengths, parity modes and stop counts.
        for (int b = 0; b < 60; b++) begin
            int k;
            cfg_dbits  = CW'(5 + ($urandom % 5));
            cfg_parity = 2'($urandom);
            cfg_stop2  = 1'($urandom);
            k = 1 + ($urandom % 3);
            for (int j = 0; j < k; j++) begin
                wait_empty();
                wr(8'($urandom), 1'($urandom));
            end
            wait_done();
            chk(tx_o == 1'b1, "R2 idle high", tx_o, 1);
            clear_done(1'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule